// File: doc/BRIEF.md
# Time-of-Arrival Lane Sorter

This block takes a single stream of pixel hit words and spreads it over sixteen output lanes. Each hit carries a 10-bit time of arrival, an 8-bit column, an 8-bit row and a 4-bit energy value. The low four bits of the time of arrival pick the lane, so every hit from the same crossing, counted modulo 16, lands in the same lane. The clustering stage that follows can then work on each lane without looking at the others.

Incoming hits first pass through a shallow FIFO that absorbs bursts. A router inspects the hit at the head of the FIFO and offers it to its lane. Each lane has a one-entry output register with its own valid/ready handshake. A lane whose consumer is slow fills its register. After that, a hit bound for that lane waits at the FIFO head and holds back every hit behind it, so no hit is dropped and order within each lane is kept. Only one hit moves from the FIFO to a lane in any cycle. A lane can sit idle for many cycles when no crossing maps to it.

Top module: `toa_lane_sorter`

## Requirements
- R1: After reset every lane valid is low, the FIFO empty flag is high, the full flag is low and `in_ready` is high.
- R2: A hit whose time of arrival is T leaves on lane T mod 16. Its lane word is {toa[29:20], col[19:12], row[11:4], energy[3:0]} and equals the accepted input fields unchanged.
- R3: The full flag is high exactly when the FIFO holds FIFO_DEPTH hits. While it is high, `in_ready` is low and no input hit is accepted.
- R4: The empty flag is high when the FIFO holds no hit, including after all lanes have drained.
- R5: A lane that is valid but not ready keeps its valid high and its word unchanged until it is taken.
- R6: Hits leave each lane in the order they were accepted at the input.
- R7: While the hit at the FIFO head cannot enter its lane, no later hit reaches any lane.
- R8: At most one hit moves from the FIFO into the lanes per clock cycle.
- R9: A lane that receives no hit keeps its valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input hit offered |
| in_ready | output | 1 | Input hit can be taken (FIFO not full) |
| in_toa | input | 10 | Time of arrival of the input hit |
| in_col | input | 8 | Column coordinate |
| in_row | input | 8 | Row coordinate |
| in_energy | input | 4 | Energy value |
| lane_valid | output | 16 | Per-lane hit available |
| lane_ready | input | 16 | Per-lane consumer takes the hit |
| lane_data | output | 480 | Per-lane 30-bit hit words, lane i at bits [30*i+29:30*i] |
| fifo_full | output | 1 | FIFO holds its full depth |
| fifo_empty | output | 1 | FIFO holds no hit |

## Verification
The assertions assume that a lane consumer may raise or drop its ready in any cycle. They also assume that the input side only counts a hit as taken in a cycle where `in_ready` was high. Under those assumptions the properties hold for any pattern of lane stalls. The stimulus offers input only as a valid/ready transfer and changes `lane_ready` only between clock edges. It drives a sweep over all 1024 time-of-arrival values, a long run with random per-lane stalls, a fill to the full flag, and a head-of-line case in which one stalled lane blocks traffic bound for another.

// File: rtl/toa_sort_pkg.sv
// Shared hit word layout for the lane sorter.
// Assumes: field widths are fixed by the front-end pixel format.
package toa_sort_pkg;
    localparam int TOA_W = 10;
    localparam int COL_W = 8;
    localparam int ROW_W = 8;
    localparam int NRG_W = 4;

    typedef struct packed {
        logic [TOA_W-1:0] toa;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [NRG_W-1:0] nrg;
    } hit_t;

    localparam int HIT_W = $bits(hit_t);
endpackage

// File: rtl/sort_hit_fifo.sv
// Burst-smoothing FIFO in front of the lane router.
// Holds up to DEPTH hit words, presents the oldest one combinationally.
// Assumes: DEPTH is a power of two, at least 2.
module sort_hit_fifo
    import toa_sort_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  hit_t wr_data,
    output logic wr_ready,
    output logic rd_valid,
    output hit_t rd_data,
    input  logic rd_pop,
    output logic full,
    output logic empty
);
    localparam int AW = $clog2(DEPTH);

    hit_t        mem [DEPTH];
    logic [AW:0] wr_ptr;
    logic [AW:0] rd_ptr;
    logic        wr_en;
    logic        rd_en;

    // Flags from wrap-bit pointer comparison.
    always_comb begin
        empty    = (wr_ptr == rd_ptr);
        full     = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
        wr_ready = !full;
        wr_en    = wr_valid && !full;
        rd_en    = rd_pop && !empty;
        rd_valid = !empty;
        rd_data  = mem[rd_ptr[AW-1:0]];
    end

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    // Pointer advance on accepted write and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R3: a full FIFO stays full until something is popped.
    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_pop) |=> full);

    // R4: an empty FIFO stays empty until something is offered.
    p_empty_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_valid) |=> empty);

    // R3: a write offered while full leaves the write pointer unchanged.
    p_no_write_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_pop) |=> $stable(wr_ptr));
endmodule

// File: rtl/lane_router.sv
// Decodes the FIFO head's low TOA bits into one lane request and
// pops the head only when that lane accepts it.
// Assumes: NUM_LANES = 2**LANE_BITS and LANE_BITS <= TOA width.
module lane_router
    import toa_sort_pkg::*;
#(
    parameter int LANE_BITS = 4,
    localparam int NUM_LANES = 1 << LANE_BITS
) (
    input  logic                 head_valid,
    input  hit_t                 head,
    input  logic [NUM_LANES-1:0] slot_ready,
    output logic [NUM_LANES-1:0] slot_valid,
    output logic                 pop
);
    logic [LANE_BITS-1:0] sel;

    // Lane index is the low TOA bits of the head.
    always_comb sel = head.toa[LANE_BITS-1:0];

    // One request line per lane.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_req
        always_comb slot_valid[g] = head_valid && (sel == LANE_BITS'(g));
    end

    // Head leaves only when its own lane can take it.
    always_comb pop = head_valid && slot_ready[sel];
endmodule

// File: rtl/lane_slot.sv
// One-entry output register for a single lane with valid/ready on both sides.
// Accepts a new word when empty or when the current word leaves this cycle.
// Assumes: IDX is this lane's index, used only by the routing check.
module lane_slot
    import toa_sort_pkg::*;
#(
    parameter int LANE_BITS = 4,
    parameter int IDX       = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  hit_t in_data,
    output logic in_ready,
    output logic out_valid,
    output hit_t out_data,
    input  logic out_ready
);
    logic full_q;
    hit_t data_q;

    // Free when empty or draining.
    always_comb begin
        in_ready  = !full_q || out_ready;
        out_valid = full_q;
        out_data  = data_q;
    end

    // Occupancy flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)                  full_q <= 1'b0;
        else if (in_valid && in_ready) full_q <= 1'b1;
        else if (out_ready)          full_q <= 1'b0;
    end

    // Capture the routed word.
    always_ff @(posedge clk) begin
        if (in_valid && in_ready) data_q <= in_data;
    end

    // R5: a stalled word is held.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R2: a word in this lane carries this lane's TOA bits.
    p_lane_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data.toa[LANE_BITS-1:0] == LANE_BITS'(IDX)));
endmodule

// File: rtl/toa_lane_sorter.sv
// Top: input FIFO, TOA-based router, and one output register per lane.
// Hits are binned by TOA modulo 2**LANE_BITS; a blocked head stalls all traffic.
// Assumes: lane consumers follow valid/ready; input counts a hit taken only with in_ready high.
module toa_lane_sorter
    import toa_sort_pkg::*;
#(
    parameter int LANE_BITS  = 4,
    parameter int FIFO_DEPTH = 8,
    localparam int NUM_LANES = 1 << LANE_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [TOA_W-1:0]           in_toa,
    input  logic [COL_W-1:0]           in_col,
    input  logic [ROW_W-1:0]           in_row,
    input  logic [NRG_W-1:0]           in_energy,
    output logic [NUM_LANES-1:0]       lane_valid,
    input  logic [NUM_LANES-1:0]       lane_ready,
    output logic [NUM_LANES*HIT_W-1:0] lane_data,
    output logic                       fifo_full,
    output logic                       fifo_empty
);
    hit_t                 in_hit;
    hit_t                 head;
    logic                 head_valid;
    logic                 pop;
    logic [NUM_LANES-1:0] slot_valid;
    logic [NUM_LANES-1:0] slot_ready;

    // Pack the input fields into a hit word.
    always_comb in_hit = '{toa: in_toa, col: in_col, row: in_row, nrg: in_energy};

    sort_hit_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (in_valid),
        .wr_data  (in_hit),
        .wr_ready (in_ready),
        .rd_valid (head_valid),
        .rd_data  (head),
        .rd_pop   (pop),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    lane_router #(.LANE_BITS(LANE_BITS)) u_router (
        .head_valid (head_valid),
        .head       (head),
        .slot_ready (slot_ready),
        .slot_valid (slot_valid),
        .pop        (pop)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        hit_t word;
        lane_slot #(.LANE_BITS(LANE_BITS), .IDX(g)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (slot_valid[g]),
            .in_data   (head),
            .in_ready  (slot_ready[g]),
            .out_valid (lane_valid[g]),
            .out_data  (word),
            .out_ready (lane_ready[g])
        );
        // Flatten lane word onto the output bus.
        always_comb lane_data[g*HIT_W +: HIT_W] = word;
    end

    // R8: no more than one lane loads per cycle.
    p_one_dispatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_valid & slot_ready));

    // R7: a pop happens only when the head's lane accepted it.
    p_hol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> ((slot_valid & slot_ready) != '0));

    // R9: an idle lane that was empty with no request stays empty.
    p_idle_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid == '0 && slot_valid == '0) |=> (lane_valid == '0));
endmodule

// File: tb/toa_lane_sorter_tb.sv
`timescale 1ns/1ps
module toa_lane_sorter_tb;
    import toa_sort_pkg::*;

    localparam int LB    = 4;
    localparam int NL    = 1 << LB;
    localparam int DEPTH = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [TOA_W-1:0]  in_toa = '0;
    logic [COL_W-1:0]  in_col = '0;
    logic [ROW_W-1:0]  in_row = '0;
    logic [NRG_W-1:0]  in_energy = '0;
    logic [NL-1:0]     lane_valid;
    logic [NL-1:0]     lane_ready = '0;
    logic [NL*HIT_W-1:0] lane_data;
    logic              fifo_full;
    logic              fifo_empty;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit rand_mode = 1'b0;

    hit_t          exp_q [NL][$];
    logic [NL-1:0] prev_stall = '0;
    hit_t          prev_word [NL];

    toa_lane_sorter #(.LANE_BITS(LB), .FIFO_DEPTH(DEPTH)) u_dut (
        .clk, .rst_n, .in_valid, .in_ready, .in_toa, .in_col, .in_row,
        .in_energy, .lane_valid, .lane_ready, .lane_data, .fifo_full, .fifo_empty
    );

    always #2 clk = ~clk;

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Random lane stalls while enabled.
    always @(posedge clk) if (rand_mode) #1 lane_ready = NL'($urandom);

    // Monitor: check lane outputs, hold behaviour, then record accepted inputs.
    always @(negedge clk) if (rst_n) begin
        for (int i = 0; i < NL; i++) begin
            hit_t w;
            w = lane_data[i*HIT_W +: HIT_W];
            if (prev_stall[i]) begin
                tests++;
                if (!lane_valid[i] || w != prev_word[i]) begin
                    fails++;
                    $display("FAIL R5 lane %0d: got v=%0b %h exp v=1 %h", i, lane_valid[i], w, prev_word[i]);
                end
            end
            prev_stall[i] = lane_valid[i] && !lane_ready[i];
            prev_word[i]  = w;
            if (lane_valid[i] && lane_ready[i]) begin
                tests++;
                if (exp_q[i].size() == 0) begin
                    fails++;
                    $display("FAIL R9 lane %0d: got %h exp none", i, w);
                end else begin
                    hit_t e;
                    e = exp_q[i].pop_front();
                    if (w != e) begin
                        fails++;
                        $display("FAIL R2/R6 lane %0d: got %h exp %h", i, w, e);
                    end
                end
            end
        end
        if (in_valid && in_ready)
            exp_q[int'(in_toa[LB-1:0])].push_back('{toa: in_toa, col: in_col, row: in_row, nrg: in_energy});
    end

    task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    // Offer one hit for up to max_wait cycles; ok reports acceptance.
    task automatic push(input logic [9:0] t, input int max_wait, output bit ok);
        int w = 0;
        in_toa = t; in_col = t[7:0] ^ 8'h5A; in_row = 8'(t >> 2); in_energy = t[3:0] ^ 4'h9;
        in_valid = 1'b1;
        ok = 1'b0;
        while (w < max_wait && !ok) begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk); #1;
            w++;
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        lane_ready = '1;
        repeat (DEPTH * 4 + 10) @(posedge clk);
        #1;
    endtask

    initial begin
        bit ok;
        int acc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(lane_valid == '0, "R1 lane_valid", 64'(lane_valid), 0);
        check(fifo_empty && !fifo_full, "R1 flags", {fifo_empty, fifo_full}, 2'b10);
        check(in_ready, "R1 in_ready", 64'(in_ready), 1);
        @(posedge clk); #1;

        // R2/R6: sweep every TOA value with all lanes ready.
        lane_ready = '1;
        for (int t = 0; t < 1024; t++) push(10'(t), 100, ok);
        drain();
        check(fifo_empty, "R4 empty after sweep", 64'(fifo_empty), 1);

        // R5/R6: random stalls.
        rand_mode = 1'b1;
        for (int k = 0; k < 1500; k++) push(10'($urandom), 200, ok);
        rand_mode = 1'b0;
        @(posedge clk); #1;
        drain();

        // R3: fill with all lanes stalled; FIFO plus one lane slot.
        lane_ready = '0;
        acc = 0;
        for (int k = 0; k < DEPTH + 4; k++) begin
            push(10'(16 * k), 3, ok);
            if (ok) acc++;
        end
        check(acc == DEPTH + 1, "R3 accepted count", 64'(acc), DEPTH + 1);
        @(negedge clk);
        check(fifo_full && !in_ready, "R3 full blocks input", {fifo_full, in_ready}, 2'b10);
        check(lane_valid == 16'h0001, "R9 only lane 0 valid", 64'(lane_valid), 16'h0001);
        @(posedge clk); #1;
        drain();
        check(exp_q[0].size() == 0, "R3 all lane0 hits out", 64'(exp_q[0].size()), 0);
        check(fifo_empty && !fifo_full, "R4 empty after drain", {fifo_empty, fifo_full}, 2'b10);

        // R7: lane 3 stalled with a second lane-3 hit at the head blocks a lane-5 hit.
        lane_ready = '0;
        push(10'd3, 5, ok);
        push(10'd19, 5, ok);
        push(10'd5, 5, ok);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(lane_valid == 16'h0008, "R7 head blocks lane5", 64'(lane_valid), 16'h0008);
        check(lane_data[3*HIT_W + 20 +: 10] == 10'd3, "R6 first lane3 hit", 64'(lane_data[3*HIT_W + 20 +: 10]), 3);
        @(posedge clk); #1;
        lane_ready = 16'h0008;
        repeat (4) @(posedge clk);
        #1 lane_ready = '0;
        @(negedge clk);
        check(lane_valid == 16'h0020, "R7 lane5 after release", 64'(lane_valid), 16'h0020);
        @(posedge clk); #1;
        drain();

        // Every expected hit delivered.
        for (int i = 0; i < NL; i++)
            check(exp_q[i].size() == 0, "R6 queue empty", 64'(exp_q[i].size()), 0);
        @(negedge clk);
        check(lane_valid == '0 && fifo_empty, "R9 idle at end", 64'(lane_valid), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule